// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Operand Conditioning

This block is the arithmetic and logic stage of a small 16-bit processor. It takes two register operands and an 8-bit constant taken from an instruction. It also takes a carry input and a set of control lines. From these it produces a 16-bit result, a carry flag, a zero flag and a negative flag. The processor's conditional branch logic reads these flags.

The second operand is prepared before any unit sees it. A select line can swap the register value for the constant, widened with zeros. A subtract line then inverts that operand. The same subtract line also inverts the carry fed to the adder, so one adder performs plain add, add-with-carry, subtract and subtract-with-borrow.

Three units work side by side on the prepared operands:
- a single-bit shifter and rotator that uses only the first operand;
- a lookahead adder built from 4-bit groups;
- bitwise AND, OR and XOR logic.

A 3-bit function code picks the result. The result and the flags are captured in one register stage, so they appear one clock after the inputs are applied.

Top module: `alu16_core`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a clock edge sampled with it low, `y_o` is 0, `cout_o` is 0, `neg_o` is 0 and `zero_o` is 1.
- R2: With `rst_n` high, the outputs show the function of the inputs sampled at the previous rising clock edge.
- R3: When `use_k_i` is 1, the second operand is `{8'h00, k_i}` instead of `b_i`.
- R4: Function code 3'b100 gives `{cout_o, y_o} = A + Bc + (cin_i ^ sub_i)`, where Bc is the selected second operand, inverted bitwise when `sub_i` is 1.
- R5: Function code 3'b000 gives `y_o` = 0.
- R6: Function code 3'b010 passes A to `y_o`. Function code 3'b011 gives the bitwise complement of A.
- R7: Function codes 3'b101, 3'b110 and 3'b111 give A AND Bc, A OR Bc and A XOR Bc. Bc is the conditioned operand defined in R4.
- R8: Function code 3'b001 with `sh_right_i` = 0 shifts A left by one and puts A[15] on `cout_o`.
  - Bit 0 gets 0 when `sh_rot_i` = 0.
  - Bit 0 gets `cin_i` when `sh_rot_i` = 1.
- R9: Function code 3'b001 with `sh_right_i` = 1 shifts A right by one and puts A[0] on `cout_o`. Bit 15 is filled as follows:
  - `cin_i` when `sh_rot_i` = 1, whatever the value of `sh_arith_i`;
  - A[15] when `sh_arith_i` = 1 and `sh_rot_i` = 0;
  - 0 when both are 0.
- R10: The shift result ignores `b_i`, `k_i`, `use_k_i` and `sub_i`. Rotates use `cin_i` without the inversion applied for subtraction.
- R11: `zero_o` is 1 exactly when `y_o` is 0. `neg_o` equals `y_o[15]`.
- R12: `cout_o` is 0 for every function code other than 3'b001 and 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second register operand |
| k_i | input | 8 | Constant from the instruction |
| use_k_i | input | 1 | Replace the second operand with the constant |
| sub_i | input | 1 | Invert the second operand and the adder carry |
| cin_i | input | 1 | Carry input |
| fn_i | input | 3 | Function code |
| sh_arith_i | input | 1 | Sign fill for right shifts |
| sh_right_i | input | 1 | Shift direction, 1 = right |
| sh_rot_i | input | 1 | Rotate through carry instead of shift |
| y_o | output | 16 | Registered result |
| cout_o | output | 1 | Registered carry flag |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |

## Verification
The subtract control and the carry input both reach the adder and the rotator in the same cycle. The subtract control is meant to change only the adder's view of the carry, not the rotator's. The bench applies rotate operations with `sub_i` high, both levels of `cin_i`, and a constant selected in place of `b_i`. The bit that fills the vacated position must equal the raw carry input. The bench then runs add and subtract operations with the same carry levels and checks both the carry and the sum.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int DATA_W  = 16;
    localparam int CONST_W = 8;
    localparam int CLA_GRP = 4;

    typedef enum logic [2:0] {
        FN_CLEAR = 3'b000,
        FN_SHIFT = 3'b001,
        FN_PASS  = 3'b010,
        FN_INV   = 3'b011,
        FN_SUM   = 3'b100,
        FN_AND   = 3'b101,
        FN_OR    = 3'b110,
        FN_XOR   = 3'b111
    } alu_fn_e;
endpackage

// File: rtl/alu16_bprep.sv
module alu16_bprep #(
    parameter int WIDTH = 16,
    parameter int KW    = 8
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic [KW-1:0]    k_i,
    input  logic             use_k_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] bc_o
);
    localparam int PAD = WIDTH - KW;

    logic [WIDTH-1:0] sel;

    always_comb begin
        sel  = use_k_i ? {{PAD{1'b0}}, k_i} : b_i;
        bc_o = sel ^ {WIDTH{sub_i}};
    end
endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             cin_i,
    input  logic             arith_i,
    input  logic             right_i,
    input  logic             rot_i,
    output logic [WIDTH-1:0] y_o,
    output logic             co_o
);
    localparam int MSB = WIDTH - 1;

    logic fill;

    always_comb begin
        if (right_i) begin
            // Bit entering at the top.
            if (rot_i)        fill = cin_i;
            else if (arith_i) fill = a_i[MSB];
            else              fill = 1'b0;
            y_o  = {fill, a_i[MSB:1]};
            co_o = a_i[0];
        end else begin
            // Bit entering at the bottom.
            fill = rot_i ? cin_i : 1'b0;
            y_o  = {a_i[MSB-1:0], fill};
            co_o = a_i[MSB];
        end
    end
endmodule

// File: rtl/alu16_cla.sv
module alu16_cla #(
    parameter int WIDTH = 16,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] s_o,
    output logic             co_o
);
    localparam int NGRP = WIDTH / GRP;

    logic [NGRP:0] gc;    // carries between groups

    assign gc[0] = cin_i;
    assign co_o  = gc[NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GRP-1:0] gen, prop;
        logic [GRP:0]   c;

        always_comb begin
            gen  = a_i[g*GRP +: GRP] & b_i[g*GRP +: GRP];
            prop = a_i[g*GRP +: GRP] ^ b_i[g*GRP +: GRP];

            // Every carry is a flat sum of products of generate and propagate terms.
            for (int j = 0; j <= GRP; j++) begin
                logic term;
                term = gc[g];
                for (int q = 0; q < j; q++) term = term & prop[q];
                c[j] = term;
                for (int m = 0; m < j; m++) begin
                    term = gen[m];
                    for (int q = m + 1; q < j; q++) term = term & prop[q];
                    c[j] = c[j] | term;
                end
            end
        end

        assign s_o[g*GRP +: GRP] = prop ^ c[GRP-1:0];
        assign gc[g+1]           = c[GRP];
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int KW    = CONST_W,
    parameter int GRP   = CLA_GRP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [KW-1:0]    k_i,
    input  logic             use_k_i,
    input  logic             sub_i,
    input  logic             cin_i,
    input  logic [2:0]       fn_i,
    input  logic             sh_arith_i,
    input  logic             sh_right_i,
    input  logic             sh_rot_i,
    output logic [WIDTH-1:0] y_o,
    output logic             cout_o,
    output logic             zero_o,
    output logic             neg_o
);
    typedef struct packed {
        logic [WIDTH-1:0] y;
        logic             c;
        logic             z;
        logic             n;
    } res_t;

    localparam res_t RES_RST = '{y: '0, c: 1'b0, z: 1'b1, n: 1'b0};

    logic [WIDTH-1:0] bc, sh_y, sum_y;
    logic             sh_c, sum_c;
    res_t             res_d, res_q;

    alu16_bprep #(.WIDTH(WIDTH), .KW(KW)) u_bprep (
        .b_i(b_i), .k_i(k_i), .use_k_i(use_k_i), .sub_i(sub_i), .bc_o(bc)
    );

    alu16_shifter #(.WIDTH(WIDTH)) u_shift (
        .a_i(a_i), .cin_i(cin_i), .arith_i(sh_arith_i), .right_i(sh_right_i),
        .rot_i(sh_rot_i), .y_o(sh_y), .co_o(sh_c)
    );

    alu16_cla #(.WIDTH(WIDTH), .GRP(GRP)) u_add (
        .a_i(a_i), .b_i(bc), .cin_i(cin_i ^ sub_i), .s_o(sum_y), .co_o(sum_c)
    );

    always_comb begin
        res_d   = RES_RST;
        res_d.c = 1'b0;
        unique case (alu_fn_e'(fn_i))
            FN_CLEAR: res_d.y = '0;
            FN_SHIFT: begin res_d.y = sh_y;  res_d.c = sh_c;  end
            FN_PASS:  res_d.y = a_i;
            FN_INV:   res_d.y = ~a_i;
            FN_SUM:   begin res_d.y = sum_y; res_d.c = sum_c; end
            FN_AND:   res_d.y = a_i & bc;
            FN_OR:    res_d.y = a_i | bc;
            FN_XOR:   res_d.y = a_i ^ bc;
            default:  res_d.y = '0;
        endcase
        res_d.z = ~|res_d.y;
        res_d.n = res_d.y[WIDTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= RES_RST;
        else        res_q <= res_d;
    end

    assign y_o    = res_q.y;
    assign cout_o = res_q.c;
    assign zero_o = res_q.z;
    assign neg_o  = res_q.n;
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
    parameter int WIDTH = 16,
    parameter int KW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [KW-1:0]    k_i,
    input logic             use_k_i,
    input logic             sub_i,
    input logic             cin_i,
    input logic [2:0]       fn_i,
    input logic             sh_right_i,
    input logic [WIDTH-1:0] y_o,
    input logic             cout_o,
    input logic             zero_o,
    input logic             neg_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   ref_sum;
    logic [WIDTH-1:0] ref_b;

    always_comb begin
        ref_b   = (use_k_i ? WIDTH'(k_i) : b_i);
        ref_b   = sub_i ? ~ref_b : ref_b;
        ref_sum = {1'b0, a_i} + {1'b0, ref_b} + (WIDTH+1)'(cin_i ^ sub_i);
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (y_o == '0 && !cout_o && zero_o && !neg_o));

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_i) == 3'b010) |-> y_o == $past(a_i));

    p_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_i) == 3'b100) |-> {cout_o, y_o} == $past(ref_sum));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_i) == 3'b000) |-> y_o == '0);

    p_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_i) == 3'b011) |-> y_o == ~$past(a_i));

    p_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_i) == 3'b001 && !$past(sh_right_i))
        |-> (y_o[MSB:1] == $past(a_i[MSB-1:0]) && cout_o == $past(a_i[MSB])));

    p_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_i) == 3'b001 && $past(sh_right_i))
        |-> (y_o[MSB-1:0] == $past(a_i[MSB:1]) && cout_o == $past(a_i[0])));

    p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o == (y_o == '0)) && (neg_o == y_o[MSB]));

    p_quiet_carry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fn_i) != 3'b001 && $past(fn_i) != 3'b100) |-> !cout_o);
endmodule

bind alu16_core alu16_core_chk #(.WIDTH(WIDTH), .KW(KW)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .k_i(k_i),
    .use_k_i(use_k_i), .sub_i(sub_i), .cin_i(cin_i), .fn_i(fn_i),
    .sh_right_i(sh_right_i), .y_o(y_o), .cout_o(cout_o),
    .zero_o(zero_o), .neg_o(neg_o)
);

// File: tb/tb_alu16_core.sv
`timescale 1ns/1ps
module tb_alu16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_i = '0, b_i = '0;
    logic [7:0]  k_i = '0;
    logic        use_k_i = 0, sub_i = 0, cin_i = 0;
    logic [2:0]  fn_i = '0;
    logic        sh_arith_i = 0, sh_right_i = 0, sh_rot_i = 0;
    logic [15:0] y_o;
    logic        cout_o, zero_o, neg_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [18:0] exp;   // {y, c, z, n}
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    alu16_core dut (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .k_i(k_i),
        .use_k_i(use_k_i), .sub_i(sub_i), .cin_i(cin_i), .fn_i(fn_i),
        .sh_arith_i(sh_arith_i), .sh_right_i(sh_right_i), .sh_rot_i(sh_rot_i),
        .y_o(y_o), .cout_o(cout_o), .zero_o(zero_o), .neg_o(neg_o)
    );

    function automatic logic [18:0] model(
        logic [15:0] a, logic [15:0] b, logic [7:0] k, logic uk, logic sb_,
        logic ci, logic [2:0] fn, logic ar, logic rt, logic ro);
        logic [15:0] op, y;
        logic [16:0] wide;
        logic        c;
        op = uk ? {8'h00, k} : b;
        if (sb_) op = ~op;
        c = 1'b0;
        y = 16'h0000;
        case (fn)
            3'd1: begin
                if (!rt) begin
                    y = (a << 1) | {15'd0, ro & ci};
                    c = a[15];
                end else begin
                    y = a >> 1;
                    if (ro)      y[15] = ci;
                    else if (ar) y[15] = a[15];
                    c = a[0];
                end
            end
            3'd2: y = a;
            3'd3: y = ~a;
            3'd4: begin
                wide = {1'b0, a} + {1'b0, op} + {16'd0, ci ^ sb_};
                y = wide[15:0];
                c = wide[16];
            end
            3'd5: y = a & op;
            3'd6: y = a | op;
            3'd7: y = a ^ op;
            default: y = 16'h0000;
        endcase
        return {y, c, (y == 16'h0000), y[15]};
    endfunction

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [7:0] k,
                         input logic uk, input logic sb_, input logic ci, input logic [2:0] fn,
                         input logic ar, input logic rt, input logic ro, input string tag);
        item_t it;
        @(negedge clk);
        a_i = a; b_i = b; k_i = k; use_k_i = uk; sub_i = sb_; cin_i = ci;
        fn_i = fn; sh_arith_i = ar; sh_right_i = rt; sh_rot_i = ro;
        it.exp = model(a, b, k, uk, sb_, ci, fn, ar, rt, ro);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: one result per clock, taken after the register has updated.
    always @(posedge clk) begin
        item_t it;
        #2;
        if (rst_n && sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if ({y_o, cout_o, zero_o, neg_o} !== it.exp) begin
                errors++;
                $display("FAIL %s: got y=%h c=%b z=%b n=%b, expected y=%h c=%b z=%b n=%b",
                         it.tag, y_o, cout_o, zero_o, neg_o,
                         it.exp[18:3], it.exp[2], it.exp[1], it.exp[0]);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state with active operands on the inputs
        a_i = 16'hffff; fn_i = 3'd2;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if ({y_o, cout_o, zero_o, neg_o} !== {16'h0000, 1'b0, 1'b1, 1'b0}) begin
            errors++;
            $display("FAIL R1: got y=%h c=%b z=%b n=%b, expected y=0000 c=0 z=1 n=0",
                     y_o, cout_o, zero_o, neg_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R6: pass and invert, one cycle latency
        drive(16'h8001, 16'h1234, 8'h00, 0, 0, 0, 3'd2, 0, 0, 0, "R2 pass");
        drive(16'h00ff, 16'h1234, 8'h00, 0, 0, 1, 3'd3, 0, 0, 0, "R6 invert");
        drive(16'hffff, 16'h0000, 8'h00, 0, 0, 0, 3'd3, 0, 0, 0, "R6 invert to zero R11");
        // R5: clear
        drive(16'hbeef, 16'hffff, 8'h00, 0, 1, 1, 3'd0, 0, 0, 0, "R5 clear R12");
        // R4: add, add with carry, subtract, subtract with borrow
        drive(16'h1234, 16'h0001, 8'h00, 0, 0, 0, 3'd4, 0, 0, 0, "R4 add");
        drive(16'hffff, 16'h0001, 8'h00, 0, 0, 0, 3'd4, 0, 0, 0, "R4 add wrap R11");
        drive(16'h7fff, 16'h0000, 8'h00, 0, 0, 1, 3'd4, 0, 0, 0, "R4 addc");
        drive(16'h0005, 16'h0003, 8'h00, 0, 1, 0, 3'd4, 0, 0, 0, "R4 sub");
        drive(16'h0003, 16'h0005, 8'h00, 0, 1, 0, 3'd4, 0, 0, 0, "R4 sub negative");
        drive(16'h0005, 16'h0003, 8'h00, 0, 1, 1, 3'd4, 0, 0, 0, "R4 subc borrow");
        // R3: constant replaces B
        drive(16'h0100, 16'hffff, 8'hff, 1, 0, 0, 3'd4, 0, 0, 0, "R3 const add");
        drive(16'h0100, 16'h1234, 8'h01, 1, 1, 0, 3'd4, 0, 0, 0, "R3 const sub");
        drive(16'hf0f0, 16'h0000, 8'h5a, 1, 0, 0, 3'd6, 0, 0, 0, "R3 const or");
        // R7: logic on conditioned B
        drive(16'hff00, 16'h0ff0, 8'h00, 0, 0, 1, 3'd5, 0, 0, 0, "R7 and");
        drive(16'hff00, 16'h0ff0, 8'h00, 0, 1, 0, 3'd5, 0, 0, 0, "R7 and inverted");
        drive(16'h1200, 16'h0034, 8'h00, 0, 0, 0, 3'd6, 0, 0, 0, "R7 or");
        drive(16'haaaa, 16'haaaa, 8'h00, 0, 0, 0, 3'd7, 0, 0, 0, "R7 xor zero");
        drive(16'haaaa, 16'haaaa, 8'h00, 0, 1, 0, 3'd7, 0, 0, 0, "R7 xor inverted");
        // R8: left shift and rotate
        drive(16'h8001, 16'h0000, 8'h00, 0, 0, 1, 3'd1, 0, 0, 0, "R8 shl");
        drive(16'h4001, 16'h0000, 8'h00, 0, 0, 1, 3'd1, 0, 0, 1, "R8 rolc");
        drive(16'h4001, 16'h0000, 8'h00, 0, 0, 0, 3'd1, 1, 0, 1, "R8 rolc cin0");
        // R9: right shifts
        drive(16'h8003, 16'h0000, 8'h00, 0, 0, 1, 3'd1, 0, 1, 0, "R9 shr");
        drive(16'h8002, 16'h0000, 8'h00, 0, 0, 0, 3'd1, 1, 1, 0, "R9 ashr");
        drive(16'h4002, 16'h0000, 8'h00, 0, 0, 1, 3'd1, 1, 1, 0, "R9 ashr positive");
        drive(16'h0001, 16'h0000, 8'h00, 0, 0, 1, 3'd1, 0, 1, 1, "R9 rorc");
        drive(16'h8000, 16'h0000, 8'h00, 0, 0, 0, 3'd1, 1, 1, 1, "R9 rorc ignores arith");
        // R10: shifter ignores B, constant and subtract; rotate uses raw carry
        drive(16'h1235, 16'hffff, 8'hff, 1, 1, 1, 3'd1, 0, 1, 1, "R10 rorc with sub");
        drive(16'h1235, 16'h0000, 8'h00, 0, 1, 0, 3'd1, 0, 0, 1, "R10 rolc with sub");
        drive(16'h1235, 16'h5555, 8'h33, 0, 1, 1, 3'd1, 0, 0, 0, "R10 shl with b");
        drive(16'h1235, 16'h5555, 8'h33, 1, 1, 1, 3'd4, 0, 0, 0, "R10 adder sees sub");
        // R12: carry quiet after a carrying op
        drive(16'hffff, 16'h0001, 8'h00, 0, 0, 1, 3'd4, 0, 0, 0, "R4 carry set");
        drive(16'hffff, 16'hffff, 8'h00, 0, 0, 1, 3'd6, 0, 0, 0, "R12 or clears carry");

        // Broad sweep with pseudo-random operands
        for (int i = 0; i < 400; i++) begin
            drive(16'($urandom), 16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  "R2 sweep");
        end

        @(negedge clk);
        fn_i = 3'd0;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: got %0d unchecked results, expected 0", sb.size());
        end
        finish_run();
    end
endmodule